// File: doc/BRIEF.md
# Power-up reset sequencing controller

This block keeps the chip in reset from the moment the supply comes up until a chain of timed waits has completed, and then lets it run. The waits always come in the same order: a power-up timer counted on a slow RC tick, an oscillator start-up count of 1024 main-oscillator cycles, and a PLL lock wait counted on the RC tick. Each wait is skipped when its configuration bit or the oscillator mode does not call for it. The power-good input acts as the block's power-on reset. The brown-out comparator input is filtered so that short supply dips are ignored.

A brown-out that outlasts the filter sends the sequence back to a brown-out phase. The block holds reset there until the supply recovers, then runs the power-up timer again. A supply-low indication while the power-up timer is running aborts the timer at once and restarts it from zero after recovery. A wake-from-sleep request in the running phase repeats only the oscillator and PLL waits. A status output always reports the current phase. The whole block runs on the main oscillator clock, and the RC tick enters it as a one-cycle strobe in that domain.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While pwr_good is low the phase is POR and chip_rst is 1. chip_rst is 1 in every phase other than RUN. It falls on the same clock edge on which the phase becomes RUN.
- R2: On leaving POR or BOR with cfg_pwrt_en=1, the phase is PWRT for exactly PWRT_TICKS rc_tick strobes. With cfg_pwrt_en=0, PWRT is skipped and the next wait in the chain follows directly.
- R3: The OST phase lasts exactly 1024 clk_osc cycles, unless a brown-out ends it early.
- R4: OST is entered only when cfg_osc_mode is LP=0, XT=1, HS=2 or HS4=3. RC=4, EC=5 and the unused codes 6 and 7 skip it.
- R5: With cfg_pll_en=1, the PLL phase follows OST (or takes its place when OST is skipped) and lasts PLL_TICKS rc_tick strobes. With cfg_pll_en=0 it is skipped.
- R6: In OST, PLL or RUN with cfg_bor_en=1, supply_low held through BOR_TICKS rc_tick strobes moves the phase to BOR one cycle after the last of those strobes. A dip that spans fewer strobes has no effect.
- R7: BOR is held while supply_low is 1. In the cycle after supply_low returns to 0, the phase becomes PWRT, or the next enabled wait when the timer is disabled.
- R8: supply_low=1 with cfg_bor_en=1 during PWRT moves the phase to BOR on the next edge, without filtering. The timer that follows recovery counts a full PWRT_TICKS strobes again.
- R9: A one-cycle wake_req in RUN starts the chain at OST or PLL and never enters PWRT. When neither wait applies, the block stays in RUN with chip_rst at 0. wake_req outside RUN has no effect.
- R10: With cfg_bor_en=0, supply_low has no effect in any phase.
- R11: The phase output is encoded POR=0, BOR=1, PWRT=2, OST=3, PLL=4, RUN=5.
- R12: When a filtered brown-out and wake_req arrive in the same RUN cycle, the brown-out wins and the phase becomes BOR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Main oscillator clock |
| pwr_good | input | 1 | Power-good indication, low acts as power-on reset (asynchronous) |
| rc_tick | input | 1 | One-cycle strobe from the slow RC oscillator |
| supply_low | input | 1 | Brown-out comparator output, 1 when the supply is below threshold |
| wake_req | input | 1 | Wake-from-sleep request strobe |
| cfg_pwrt_en | input | 1 | Enables the power-up timer wait |
| cfg_bor_en | input | 1 | Enables brown-out detection |
| cfg_osc_mode | input | 3 | Oscillator mode: LP=0, XT=1, HS=2, HS4=3, RC=4, EC=5 |
| cfg_pll_en | input | 1 | Enables the PLL lock wait |
| chip_rst | output | 1 | Chip reset, active high |
| phase | output | 3 | Current sequence phase |

## Verification
Two functions can act on the same cycle in RUN: a filtered brown-out trip and a wake request. The bench lowers the supply, counts RC strobes until the third one has been consumed, and pulses wake_req in the cycle in which the filter reports the trip. The design passes only if the phase then reads BOR and not OST. The same kind of collision inside the power-up timer is also provoked: a supply dip arrives partway through the count, and the bench confirms that the restarted timer again counts a full number of strobes.

// File: rtl/pwrup_rst_seq_pkg.sv
package pwrup_rst_seq_pkg;

    typedef enum logic [2:0] {
        PH_POR  = 3'd0,
        PH_BOR  = 3'd1,
        PH_PWRT = 3'd2,
        PH_OST  = 3'd3,
        PH_PLL  = 3'd4,
        PH_RUN  = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        OSC_LP  = 3'd0,
        OSC_XT  = 3'd1,
        OSC_HS  = 3'd2,
        OSC_HS4 = 3'd3,
        OSC_RC  = 3'd4,
        OSC_EC  = 3'd5
    } osc_mode_e;

    localparam int OST_CYCLES = 1024;

    // Crystal and resonator modes need the start-up count
    function automatic logic osc_needs_startup(input logic [2:0] mode);
        return (mode <= OSC_HS4);
    endfunction

endpackage

// File: rtl/pwrup_bor_filter.sv
module pwrup_bor_filter #(
    parameter int BOR_TICKS = 8
) (
    input  logic clk_osc,
    input  logic pwr_good,
    input  logic enable_i,
    input  logic low_i,
    input  logic tick_i,
    output logic trip_o
);
    localparam int FCW = $clog2(BOR_TICKS + 1);
    localparam logic [FCW-1:0] FULL = FCW'(BOR_TICKS);

    typedef struct packed {
        logic [FCW-1:0] cnt;
    } filt_t;

    filt_t f_d, f_q;
    logic  armed;

    assign armed = enable_i && low_i;

    always_comb begin
        f_d = f_q;
        if (!armed) begin
            f_d.cnt = '0;
        end else if (tick_i && (f_q.cnt != FULL)) begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_osc or negedge pwr_good) begin
        if (!pwr_good) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign trip_o = armed && (f_q.cnt == FULL);

endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
    import pwrup_rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS = 72,
    parameter int PLL_TICKS  = 64
) (
    input  logic       clk_osc,
    input  logic       pwr_good,
    input  logic       rc_tick,
    input  logic       supply_low,
    input  logic       bor_trip,
    input  logic       wake_req,
    input  logic       cfg_pwrt_en,
    input  logic       cfg_bor_en,
    input  logic [2:0] cfg_osc_mode,
    input  logic       cfg_pll_en,
    output phase_e     phase_o,
    output logic       rst_o
);
    localparam int MAX_A = (PWRT_TICKS > PLL_TICKS) ? PWRT_TICKS : PLL_TICKS;
    localparam int MAX_W = (MAX_A > OST_CYCLES) ? MAX_A : OST_CYCLES;
    localparam int CW    = $clog2(MAX_W);
    localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_TICKS - 1);
    localparam logic [CW-1:0] OST_LAST  = CW'(OST_CYCLES - 1);
    localparam logic [CW-1:0] PLL_LAST  = CW'(PLL_TICKS - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          rst;
    } seq_t;

    seq_t   s_d, s_q;
    phase_e after_ost;
    phase_e after_timer;
    phase_e after_supply;
    logic   raw_low;

    // Fixed chain: timer, then start-up count, then PLL lock
    always_comb begin
        after_ost    = cfg_pll_en ? PH_PLL : PH_RUN;
        after_timer  = osc_needs_startup(cfg_osc_mode) ? PH_OST : after_ost;
        after_supply = cfg_pwrt_en ? PH_PWRT : after_timer;
        raw_low      = cfg_bor_en && supply_low;
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_POR: begin
                s_d.phase = after_supply;
                s_d.cnt   = '0;
            end
            PH_BOR: begin
                s_d.cnt = '0;
                if (!raw_low) begin
                    s_d.phase = after_supply;
                end
            end
            PH_PWRT: begin
                if (raw_low) begin
                    s_d.phase = PH_BOR;
                    s_d.cnt   = '0;
                end else if (rc_tick) begin
                    if (s_q.cnt == PWRT_LAST) begin
                        s_d.phase = after_timer;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            PH_OST: begin
                if (bor_trip) begin
                    s_d.phase = PH_BOR;
                    s_d.cnt   = '0;
                end else if (s_q.cnt == OST_LAST) begin
                    s_d.phase = after_ost;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_PLL: begin
                if (bor_trip) begin
                    s_d.phase = PH_BOR;
                    s_d.cnt   = '0;
                end else if (rc_tick) begin
                    if (s_q.cnt == PLL_LAST) begin
                        s_d.phase = PH_RUN;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            PH_RUN: begin
                s_d.cnt = '0;
                if (bor_trip) begin
                    s_d.phase = PH_BOR;
                end else if (wake_req) begin
                    s_d.phase = after_timer;
                end
            end
            default: begin
                s_d.phase = PH_POR;
                s_d.cnt   = '0;
            end
        endcase
        s_d.rst = (s_d.phase != PH_RUN);
    end

    always_ff @(posedge clk_osc or negedge pwr_good) begin
        if (!pwr_good) begin
            s_q.phase <= PH_POR;
            s_q.cnt   <= '0;
            s_q.rst   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign rst_o   = s_q.rst;

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
    import pwrup_rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS = 72,
    parameter int BOR_TICKS  = 8,
    parameter int PLL_TICKS  = 64
) (
    input  logic       clk_osc,
    input  logic       pwr_good,
    input  logic       rc_tick,
    input  logic       supply_low,
    input  logic       wake_req,
    input  logic       cfg_pwrt_en,
    input  logic       cfg_bor_en,
    input  logic [2:0] cfg_osc_mode,
    input  logic       cfg_pll_en,
    output logic       chip_rst,
    output logic [2:0] phase
);
    logic   bor_trip;
    phase_e cur_phase;

    pwrup_bor_filter #(
        .BOR_TICKS(BOR_TICKS)
    ) i_filter (
        .clk_osc (clk_osc),
        .pwr_good(pwr_good),
        .enable_i(cfg_bor_en),
        .low_i   (supply_low),
        .tick_i  (rc_tick),
        .trip_o  (bor_trip)
    );

    pwrup_seq_fsm #(
        .PWRT_TICKS(PWRT_TICKS),
        .PLL_TICKS (PLL_TICKS)
    ) i_fsm (
        .clk_osc     (clk_osc),
        .pwr_good    (pwr_good),
        .rc_tick     (rc_tick),
        .supply_low  (supply_low),
        .bor_trip    (bor_trip),
        .wake_req    (wake_req),
        .cfg_pwrt_en (cfg_pwrt_en),
        .cfg_bor_en  (cfg_bor_en),
        .cfg_osc_mode(cfg_osc_mode),
        .cfg_pll_en  (cfg_pll_en),
        .phase_o     (cur_phase),
        .rst_o       (chip_rst)
    );

    assign phase = cur_phase;

endmodule

// File: rtl/pwrup_rst_seq_chk.sv
module pwrup_rst_seq_chk
    import pwrup_rst_seq_pkg::*;
(
    input logic       clk_osc,
    input logic       pwr_good,
    input logic       supply_low,
    input logic       cfg_pwrt_en,
    input logic       cfg_bor_en,
    input logic [2:0] cfg_osc_mode,
    input logic       cfg_pll_en,
    input logic       chip_rst,
    input logic [2:0] phase
);
    logic [10:0] ost_seen;

    always_ff @(posedge clk_osc or negedge pwr_good) begin
        if (!pwr_good) begin
            ost_seen <= '0;
        end else if (phase == PH_OST) begin
            ost_seen <= ost_seen + 1'b1;
        end else begin
            ost_seen <= '0;
        end
    end

    AST_RST_OUTSIDE_RUN: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        (phase != PH_RUN) |-> chip_rst);                                     // R1
    AST_NO_RST_IN_RUN: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        (phase == PH_RUN) |-> !chip_rst);                                    // R1
    AST_OST_FULL_LENGTH: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        ($past(phase) == PH_OST && phase != PH_OST && phase != PH_BOR)
        |-> (ost_seen == 11'(OST_CYCLES)));                                  // R3
    AST_OST_MODE_GATE: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        (phase == PH_PWRT && !osc_needs_startup(cfg_osc_mode)) |=> (phase != PH_OST)); // R4
    AST_PLL_GATE: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        (phase == PH_OST && !cfg_pll_en) |=> (phase != PH_PLL));             // R5
    AST_BOR_HOLD: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        (phase == PH_BOR && supply_low && cfg_bor_en) |=> (phase == PH_BOR)); // R7
    AST_BOR_TO_TIMER: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        (phase == PH_BOR && !supply_low && cfg_pwrt_en) |=> (phase == PH_PWRT)); // R7
    AST_PWRT_ABORT: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        (phase == PH_PWRT && supply_low && cfg_bor_en) |=> (phase == PH_BOR)); // R8
    AST_WAKE_NO_TIMER: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        (phase == PH_RUN) |=> (phase != PH_PWRT));                           // R9
    AST_BOR_DISABLED: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        (!cfg_bor_en && phase != PH_POR && phase != PH_BOR) |=> (phase != PH_BOR)); // R10
    AST_PHASE_LEGAL: assert property (@(posedge clk_osc) disable iff (!pwr_good)
        phase <= PH_RUN);                                                    // R11

endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk i_chk (.*);

// File: tb/test_pwrup_rst_seq.sv
module test_pwrup_rst_seq;
    localparam int PW = 4;
    localparam int BF = 3;
    localparam int PL = 5;

    localparam logic [2:0] P_POR = 3'd0, P_BOR = 3'd1, P_PWRT = 3'd2,
                           P_OST = 3'd3, P_PLL = 3'd4, P_RUN = 3'd5;

    logic       clk_osc = 1'b0;
    logic       pwr_good = 1'b0;
    logic       rc_tick = 1'b0;
    logic       supply_low = 1'b0;
    logic       wake_req = 1'b0;
    logic       cfg_pwrt_en = 1'b1;
    logic       cfg_bor_en = 1'b1;
    logic [2:0] cfg_osc_mode = 3'd2;
    logic       cfg_pll_en = 1'b1;
    logic       chip_rst;
    logic [2:0] phase;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    pwrup_rst_seq #(.PWRT_TICKS(PW), .BOR_TICKS(BF), .PLL_TICKS(PL)) i_pwrup_rst_seq (
        .clk_osc(clk_osc), .pwr_good(pwr_good), .rc_tick(rc_tick),
        .supply_low(supply_low), .wake_req(wake_req), .cfg_pwrt_en(cfg_pwrt_en),
        .cfg_bor_en(cfg_bor_en), .cfg_osc_mode(cfg_osc_mode), .cfg_pll_en(cfg_pll_en),
        .chip_rst(chip_rst), .phase(phase)
    );

    always #5 clk_osc = ~clk_osc;

    // RC strobe: one cycle in eight, driven clear of both edges
    initial begin
        int tc = 0;
        forever begin
            @(posedge clk_osc);
            #2;
            rc_tick = (tc == 0);
            tc = (tc + 1) % 8;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_for(input logic [2:0] p, input string tag);
        int g = 0;
        while (phase != p && g < 6000) begin
            @(negedge clk_osc);
            g++;
        end
        chk(phase == p, tag, int'(phase), int'(p));
    endtask

    // Counts ticks (or cycles) seen while the phase stays at p
    task automatic count_in(input logic [2:0] p, input bit ticks, output int n, output bit rst_ok);
        int g = 0;
        n = 0;
        rst_ok = 1'b1;
        while (phase == p && g < 6000) begin
            if (!ticks || rc_tick) n++;
            if (!chip_rst) rst_ok = 1'b0;
            g++;
            @(negedge clk_osc);
        end
    endtask

    task automatic t_reset_state();
        pwr_good = 1'b0;
        repeat (3) @(negedge clk_osc);
        chk(phase == P_POR, "R11 phase in power-on reset", int'(phase), 0);
        chk(chip_rst == 1'b1, "R1 reset held while power not good", int'(chip_rst), 1);
    endtask

    task automatic t_full_power_on();
        int  n;
        bit  rok;
        cfg_pwrt_en = 1; cfg_bor_en = 1; cfg_osc_mode = 3'd2; cfg_pll_en = 1;
        pwr_good = 1'b1;
        @(negedge clk_osc);
        chk(phase == P_PWRT, "R2 timer follows power-on", int'(phase), int'(P_PWRT));
        count_in(P_PWRT, 1'b1, n, rok);
        chk(n == PW, "R2 timer tick count", n, PW);
        chk(phase == P_OST, "R4 HS mode enters start-up count", int'(phase), int'(P_OST));
        count_in(P_OST, 1'b0, n, rok);
        chk(n == 1024, "R3 start-up count length", n, 1024);
        chk(phase == P_PLL, "R5 PLL wait follows start-up", int'(phase), int'(P_PLL));
        count_in(P_PLL, 1'b1, n, rok);
        chk(n == PL, "R5 PLL tick count", n, PL);
        chk(phase == P_RUN && chip_rst == 1'b0, "R1 released on reaching RUN",
            int'(chip_rst), 0);
        chk(rok, "R1 reset held through PLL wait", int'(rok), 1);
    endtask

    task automatic t_skip_por();
        pwr_good = 1'b0; cfg_pwrt_en = 0; cfg_osc_mode = 3'd5; cfg_pll_en = 0;
        @(negedge clk_osc);
        pwr_good = 1'b1;
        @(negedge clk_osc);
        chk(phase == P_RUN && chip_rst == 1'b0, "R2 all waits skipped (EC, no timer, no PLL)",
            int'(phase), int'(P_RUN));
        pwr_good = 1'b0; cfg_osc_mode = 3'd0;
        @(negedge clk_osc);
        pwr_good = 1'b1;
        @(negedge clk_osc);
        chk(phase == P_OST, "R2 timer disabled goes straight to start-up (LP)",
            int'(phase), int'(P_OST));
        wait_for(P_RUN, "R3 reach RUN after start-up only");
    endtask

    task automatic t_short_dip();
        int n = 0;
        cfg_bor_en = 1;
        supply_low = 1'b1;
        while (1) begin
            if (rc_tick) n++;
            if (n == BF - 1) break;
            @(negedge clk_osc);
        end
        @(negedge clk_osc);
        supply_low = 1'b0;
        repeat (20) @(negedge clk_osc);
        chk(phase == P_RUN && chip_rst == 1'b0, "R6 short dip ignored", int'(phase), int'(P_RUN));
    endtask

    task automatic t_long_dip_recover();
        int n;
        bit rok;
        cfg_pwrt_en = 1; cfg_osc_mode = 3'd2; cfg_pll_en = 1; cfg_bor_en = 1;
        supply_low = 1'b1;
        count_in(P_RUN, 1'b1, n, rok);
        chk(phase == P_BOR, "R6 long dip enters BOR", int'(phase), int'(P_BOR));
        chk(n == BF, "R6 filter tick count before trip", n, BF);
        repeat (20) @(negedge clk_osc);
        chk(phase == P_BOR && chip_rst == 1'b1, "R7 BOR held while supply low",
            int'(phase), int'(P_BOR));
        supply_low = 1'b0;
        @(negedge clk_osc);
        chk(phase == P_PWRT, "R7 timer after recovery", int'(phase), int'(P_PWRT));
        n = 0;
        while (1) begin
            if (rc_tick) n++;
            if (n == 2) break;
            @(negedge clk_osc);
        end
        @(negedge clk_osc);
        supply_low = 1'b1;
        @(negedge clk_osc);
        chk(phase == P_BOR, "R8 dip during timer aborts it", int'(phase), int'(P_BOR));
        supply_low = 1'b0;
        @(negedge clk_osc);
        count_in(P_PWRT, 1'b1, n, rok);
        chk(n == PW, "R8 timer restarts from zero", n, PW);
        wait_for(P_RUN, "R5 back to RUN after recovery");
    endtask

    task automatic t_bor_disabled();
        cfg_bor_en = 0;
        supply_low = 1'b1;
        repeat (60) @(negedge clk_osc);
        chk(phase == P_RUN && chip_rst == 1'b0, "R10 supply low ignored when disabled",
            int'(phase), int'(P_RUN));
        supply_low = 1'b0;
        cfg_bor_en = 1;
        @(negedge clk_osc);
    endtask

    task automatic t_wake();
        int n;
        bit rok;
        cfg_osc_mode = 3'd2; cfg_pll_en = 1;
        wake_req = 1'b1;
        @(negedge clk_osc);
        wake_req = 1'b0;
        chk(phase == P_OST, "R9 wake enters start-up, not timer", int'(phase), int'(P_OST));
        count_in(P_OST, 1'b0, n, rok);
        chk(n == 1024, "R3 wake start-up length", n, 1024);
        count_in(P_PLL, 1'b1, n, rok);
        chk(n == PL, "R5 wake PLL tick count", n, PL);
        cfg_osc_mode = 3'd4;
        wake_req = 1'b1;
        @(negedge clk_osc);
        wake_req = 1'b0;
        chk(phase == P_PLL, "R4 RC mode skips start-up on wake", int'(phase), int'(P_PLL));
        repeat (3) @(negedge clk_osc);
        wake_req = 1'b1;
        @(negedge clk_osc);
        wake_req = 1'b0;
        wait_for(P_RUN, "R9 return to RUN");
        cfg_osc_mode = 3'd5; cfg_pll_en = 0;
        wake_req = 1'b1;
        @(negedge clk_osc);
        wake_req = 1'b0;
        @(negedge clk_osc);
        chk(phase == P_RUN && chip_rst == 1'b0, "R9 wake with no wait stays in RUN",
            int'(chip_rst), 0);
    endtask

    task automatic t_pll_wake_ignored();
        int n;
        bit rok;
        cfg_osc_mode = 3'd4; cfg_pll_en = 1;
        wake_req = 1'b1;
        @(negedge clk_osc);
        wake_req = 1'b0;
        @(negedge clk_osc);
        wake_req = 1'b1;
        @(negedge clk_osc);
        wake_req = 1'b0;
        count_in(P_PLL, 1'b1, n, rok);
        chk(phase == P_RUN, "R9 wake inside PLL wait has no effect", int'(phase), int'(P_RUN));
    endtask

    task automatic t_priority();
        int n = 0;
        cfg_osc_mode = 3'd2; cfg_pll_en = 1; cfg_bor_en = 1; cfg_pwrt_en = 1;
        supply_low = 1'b1;
        while (1) begin
            if (rc_tick) n++;
            if (n == BF) break;
            @(negedge clk_osc);
        end
        @(negedge clk_osc);
        chk(phase == P_RUN, "R12 still RUN before collision", int'(phase), int'(P_RUN));
        wake_req = 1'b1;
        @(negedge clk_osc);
        wake_req = 1'b0;
        chk(phase == P_BOR, "R12 brown-out beats wake", int'(phase), int'(P_BOR));
        supply_low = 1'b0;
        wait_for(P_RUN, "R7 recover after collision");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired phase=%0d expected=%0d", phase, P_RUN);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk_osc);
        t_reset_state();
        t_full_power_on();
        t_short_dip();
        t_long_dip_recover();
        t_bor_disabled();
        t_wake();
        t_pll_wake_ignored();
        t_priority();
        t_skip_por();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule